// File: doc/BRIEF.md
# Serial Membrane-Defining Automaton Cell

One cell of a two-dimensional cellular automaton that draws block boundaries and spare columns across a self-repairing array of logic elements. The cell listens on two one-bit serial lines, one from its south neighbour and one from its west neighbour. It captures a three-bit state code in a four-flop shift register. It decides, by fixed wiring, whether that code may enter from the direction it came. It then locks the accepted code. Every bit that arrives after that passes through the cell to its north and/or east neighbour, chosen by the kind of state it holds.

A code is sent with its always-1 leading bit first, then the middle digit, then the left digit. The four locked kinds are horizontal wall (left digit 0, middle 0), spare column (0, 1), vertical wall (1, 0) and junction (1, 1). Horizontal walls and spare columns may only spread sideways, so they are refused when they arrive from the south alone. Vertical walls may only spread upward, so they are refused when they arrive from the west alone. The locked state is also decoded into four one-hot flags for the routing logic that surrounds the cell.

A controller with five named states sequences the capture. IDLE waits for a 1 and moves to FILL1, noting which input or inputs carried that leading bit. FILL1 moves to FILL2, and FILL2 moves to DECIDE. DECIDE returns to IDLE with the register cleared when the code is refused (reject), and otherwise moves to LOCKED (accept). Only reset leaves LOCKED.

Top module: `membrane_cell`

## Requirements
- R1: While reset is asserted and just after it, the four state flops are 0000, `locked` is 0, and all flags and both serial outputs are 0.
- R2: In IDLE, cycles in which both serial inputs are 0 leave the cell quiescent: `locked` stays 0 and the outputs stay 0.
- R3: The serial input bit is the OR of `south_in` and `west_in`. Bits enter the top flop and move one flop down per clock. A leading 1 followed by the middle digit and then the left digit locks the cell on the fourth clock counted from the leading bit. The flags then name the code: horizontal wall = 00, spare column = 01, vertical wall = 10, junction = 11 (left digit, middle digit).
- R4: A horizontal wall or spare column whose leading bit came from `south_in` alone is refused. On the fourth clock the cell returns to quiescent, the bit present on that clock is discarded, and the cell can then accept a new code.
- R5: A vertical wall whose leading bit came from `west_in` alone is refused in the same way.
- R6: Every other case is accepted. This covers walls and spare columns from the west, vertical walls from the south, and junctions from either side. When both inputs carry the leading 1 in the same cycle, the code counts as coming from both directions and is never refused.
- R7: Once locked, the held code and the flags stay fixed whatever the inputs do, until reset.
- R8: When locked as a vertical wall or junction, `north_out` equals the serial input bit of the previous clock. Otherwise `north_out` is 0.
- R9: When locked as a horizontal wall, spare column or junction, `east_out` equals the serial input bit of the previous clock. Otherwise `east_out` is 0.
- R10: Until the cell is locked, `north_out`, `east_out` and all four flags are 0.
- R11: While locked, exactly one of the four flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| south_in | input | 1 | Serial bit from the south neighbour |
| west_in | input | 1 | Serial bit from the west neighbour |
| north_out | output | 1 | Serial bit forwarded to the north neighbour |
| east_out | output | 1 | Serial bit forwarded to the east neighbour |
| locked | output | 1 | Cell holds an accepted code |
| flag_hwall | output | 1 | Locked as horizontal wall |
| flag_spare | output | 1 | Locked as spare column |
| flag_vwall | output | 1 | Locked as vertical wall |
| flag_junction | output | 1 | Locked as junction |

## Verification
The accept-or-refuse result becomes visible after the fourth rising edge counted from the one that captured the leading 1. On that edge `locked` and the flags change. After it, each forwarded bit shows on `north_out` or `east_out` just after the edge that sampled it, so the outputs trail the serial input by exactly one clock. The bench changes inputs on falling edges and reads outputs shortly after the next rising edge, so every comparison falls in the cycle in which the registered result is due. It sweeps all four codes against south-only, west-only and dual-input arrival, with a distinct payload per combination. Refused cases are probed with a 1 on the deciding edge, to show that this bit is dropped.

// File: rtl/mca_pkg.sv
package mca_pkg;

    localparam int STATE_W = 4;   // Q3..Q0
    localparam int CODE_W  = 2;   // left digit, middle digit
    localparam int KINDS   = 1 << CODE_W;

    // capture sequencer
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FILL1  = 3'd1,
        PH_FILL2  = 3'd2,
        PH_DECIDE = 3'd3,
        PH_LOCKED = 3'd4
    } phase_t;

    // what the shift register does this clock
    typedef enum logic [1:0] {
        ACT_SHIFT = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_CLEAR = 2'd2
    } act_t;

    // locked code values, {left digit, middle digit}
    localparam logic [CODE_W-1:0] K_HWALL = 2'b00;
    localparam logic [CODE_W-1:0] K_SPARE = 2'b01;
    localparam logic [CODE_W-1:0] K_VWALL = 2'b10;
    localparam logic [CODE_W-1:0] K_JUNCT = 2'b11;

endpackage

// File: rtl/mca_shreg.sv
module mca_shreg
    import mca_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  act_t               act,
    input  logic               bit_in,
    output logic [STATE_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_SHIFT: q <= {bit_in, q[STATE_W-1:1]};
                ACT_HOLD:  q <= {bit_in, q[STATE_W-2:0]};
                ACT_CLEAR: q <= '0;
                default:   q <= '0;
            endcase
        end
    end

    // R7: once the low flop is set, the code flops never move
    p_frozen_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q[0] |=> $stable(q[STATE_W-2:0]));

    // R2: a quiescent register fed zeros stays quiescent
    p_quiet_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '0 && !bit_in) |=> (q == '0));

endmodule

// File: rtl/mca_ctrl.sv
module mca_ctrl
    import mca_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               south_in,
    input  logic               west_in,
    input  logic [STATE_W-1:0] q,
    output phase_t             phase,
    output act_t               act
);

    phase_t phase_nx;
    logic   org_s;
    logic   org_w;
    logic   refuse;

    // R4 / R5: direction rules on the captured digits
    always_comb begin
        refuse = 1'b0;
        if (!q[3] && org_s && !org_w)
            refuse = 1'b1;
        if (q[3] && !q[2] && org_w && !org_s)
            refuse = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            org_s <= 1'b0;
            org_w <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (phase == PH_IDLE && (south_in || west_in)) begin
                org_s <= south_in;
                org_w <= west_in;
            end
        end
    end

    // next state and register action
    always_comb begin
        phase_nx = phase;
        act      = ACT_SHIFT;
        unique case (phase)
            PH_IDLE: begin
                act = ACT_SHIFT;
                if (south_in || west_in)
                    phase_nx = PH_FILL1;
            end
            PH_FILL1: begin
                act      = ACT_SHIFT;
                phase_nx = PH_FILL2;
            end
            PH_FILL2: begin
                act      = ACT_SHIFT;
                phase_nx = PH_DECIDE;
            end
            PH_DECIDE: begin
                if (refuse) begin
                    act      = ACT_CLEAR;
                    phase_nx = PH_IDLE;
                end else begin
                    act      = ACT_SHIFT;
                    phase_nx = PH_LOCKED;
                end
            end
            PH_LOCKED: begin
                act      = ACT_HOLD;
                phase_nx = PH_LOCKED;
            end
            default: begin
                act      = ACT_CLEAR;
                phase_nx = PH_IDLE;
            end
        endcase
    end

    // R3: the sequencer decides exactly when the leading 1 sits one above the bottom
    p_decide_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECIDE) |-> (q[1] && !q[0]));

    // R3: the locked phase and the register's lock flop agree
    p_locked_agrees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOCKED) == q[0]);

    // R1 / R2: in IDLE the register is quiescent
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (q == '0));

endmodule

// File: rtl/mca_decode.sv
module mca_decode
    import mca_pkg::*;
(
    input  logic [STATE_W-1:0] q,
    output logic               locked,
    output logic [KINDS-1:0]   kind_hot,
    output logic               north_out,
    output logic               east_out
);

    logic [CODE_W-1:0] code;
    logic              go_north;
    logic              go_east;

    assign locked = q[0];
    assign code   = q[STATE_W-2:1];

    // one flag per code value, gated by lock
    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        assign kind_hot[k] = locked && (code == k[CODE_W-1:0]);
    end

    always_comb begin
        go_north = 1'b0;
        go_east  = 1'b0;
        unique case (code)
            K_HWALL: go_east  = 1'b1;
            K_SPARE: go_east  = 1'b1;
            K_VWALL: go_north = 1'b1;
            K_JUNCT: begin
                go_north = 1'b1;
                go_east  = 1'b1;
            end
            default: ;
        endcase
    end

    assign north_out = locked && go_north && q[STATE_W-1];
    assign east_out  = locked && go_east  && q[STATE_W-1];

    // R11: a locked cell names exactly one kind
    always_comb begin
        if (locked)
            p_one_kind_r11: assert ($countones(kind_hot) == 1);
    end

endmodule

// File: rtl/membrane_cell.sv
module membrane_cell
    import mca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic south_in,
    input  logic west_in,
    output logic north_out,
    output logic east_out,
    output logic locked,
    output logic flag_hwall,
    output logic flag_spare,
    output logic flag_vwall,
    output logic flag_junction
);

    logic               bit_in;
    logic [STATE_W-1:0] q;
    logic [KINDS-1:0]   kind_hot;
    phase_t             phase;
    act_t               act;

    assign bit_in = south_in | west_in;

    mca_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .south_in (south_in),
        .west_in  (west_in),
        .q        (q),
        .phase    (phase),
        .act      (act)
    );

    mca_shreg u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .bit_in (bit_in),
        .q      (q)
    );

    mca_decode u_decode (
        .q         (q),
        .locked    (locked),
        .kind_hot  (kind_hot),
        .north_out (north_out),
        .east_out  (east_out)
    );

    assign flag_hwall    = kind_hot[K_HWALL];
    assign flag_spare    = kind_hot[K_SPARE];
    assign flag_vwall    = kind_hot[K_VWALL];
    assign flag_junction = kind_hot[K_JUNCT];

    // R4 (and R5): a refusal empties the register and returns to IDLE
    p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECIDE && act == ACT_CLEAR) |=> (q == '0 && phase == PH_IDLE));

    // R10: nothing leaves and no flag shows before lock
    p_silent_before_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!north_out && !east_out && kind_hot == '0));

    // R8: north echoes the previous serial bit for upward-spreading kinds
    p_north_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (north_out == ($past(bit_in) && (flag_vwall || flag_junction))));

    // R9: east echoes the previous serial bit for sideways-spreading kinds
    p_east_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (east_out == ($past(bit_in) && !flag_vwall)));

endmodule

// File: tb/membrane_cell_bench.sv
module membrane_cell_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic south_in = 1'b0;
    logic west_in = 1'b0;
    logic north_out, east_out, locked;
    logic flag_hwall, flag_spare, flag_vwall, flag_junction;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    membrane_cell u_membrane_cell (
        .clk           (clk),
        .rst_n         (rst_n),
        .south_in      (south_in),
        .west_in       (west_in),
        .north_out     (north_out),
        .east_out      (east_out),
        .locked        (locked),
        .flag_hwall    (flag_hwall),
        .flag_spare    (flag_spare),
        .flag_vwall    (flag_vwall),
        .flag_junction (flag_junction)
    );

    function automatic logic [3:0] flags();
        return {flag_junction, flag_vwall, flag_spare, flag_hwall};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the next rising edge
    task automatic step(input logic s, input logic w);
        @(negedge clk);
        south_in = s;
        west_in  = w;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        south_in = 1'b0;
        west_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset locked", locked, 0);
        chk("R1 reset outputs", {north_out, east_out, flags()}, 0);
        rst_n = 1'b1;
    endtask

    // src: 0 south only, 1 west only, 2 both
    task automatic send_bit(input int src, input logic b);
        step(b && src != 1, b && src != 0);
    endtask

    task automatic run_case(input int code, input int src, input logic [5:0] pl);
        logic refuse;
        logic n_ok;
        logic e_ok;
        do_reset();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        chk("R2 zeros keep quiet", {locked, north_out, east_out, flags()}, 0);

        send_bit(src, 1'b1);
        send_bit(src, code[0]);
        send_bit(src, code[1]);
        chk("R10 silent before lock", {locked, north_out, east_out, flags()}, 0);

        refuse = (code < 2 && src == 0) || (code == 2 && src == 1);
        n_ok   = (code >= 2);
        e_ok   = (code != 2);

        if (refuse) begin
            send_bit(src, 1'b1);   // bit on the deciding edge must be dropped
            if (code < 2) chk("R4 refused from south", locked, 0);
            else          chk("R5 refused from west", locked, 0);
            for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
            if (code < 2) chk("R4 stays quiescent", {locked, north_out, east_out, flags()}, 0);
            else          chk("R5 stays quiescent", {locked, north_out, east_out, flags()}, 0);
            // the cell must still accept a fresh code afterwards
            send_bit(2, 1'b1);
            send_bit(2, 1'b1);
            send_bit(2, 1'b1);
            send_bit(2, 1'b0);
            chk("R4 accepts after refusal", {locked, flags()}, {1'b1, 4'b1000});
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (i[0]) step(1'b0, pl[i]);
                else      step(pl[i], 1'b0);
                if (i == 0) begin
                    chk("R6 accepted", locked, 1);
                    chk("R3 locks with code", flags(), 1 << code);
                end else begin
                    chk("R7 code frozen", {locked, flags()}, {1'b1, 4'(1 << code)});
                end
                chk("R11 one flag", $countones(flags()), 1);
                chk("R8 north echo", north_out, pl[i] && n_ok);
                chk("R9 east echo", east_out, pl[i] && e_ok);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog R1-R11 run actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int code = 0; code < 4; code++) begin
            for (int src = 0; src < 3; src++) begin
                run_case(code, src, 6'(6'b100110 + (code * 3 + src) * 7));
            end
        end
        // R7: a lock survives a stream that looks like another code
        do_reset();
        send_bit(1, 1'b1);
        send_bit(1, 1'b1);
        send_bit(1, 1'b0);
        send_bit(1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, i[0]);
        chk("R7 spare column held", {locked, flags()}, {1'b1, 4'b0010});
        chk("R9 east echo of both", east_out, 1);
        chk("R8 north blocked for spare", north_out, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule